// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Controller

This block collects up to thirty-two single-cycle interrupt pulses into a pending register. Each pending bit is qualified by a per-source mask bit and a single global enable. Software sees the state as five 16-bit registers: the pending and mask words are each split into a low and a high half, and the global enable is one more register. A pending bit stays set until software acknowledges it by writing a one into the matching position.

Two outputs go to the processor. The interrupt request is a level. It is high whenever the global enable is on and at least one pending bit is also unmasked. The wake output is a one-cycle pulse. It releases a halted core when a source that is enabled in the mask fires, whether or not the global enable is on. Priority selection and vector generation belong to the software that reads the pending word.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the pending, mask and global enable registers all read zero, and both `irq` and `wake` are low.
- R2: A pulse on `src_pulse[n]` sets pending bit n on the next clock edge. Bits 0 to 15 read back at register select 0 (low pending half), and bits 16 to 31 read back at select 1 (high pending half) in bit position n-16.
- R3: A write to select 0 or 1 clears every pending bit in that half whose data bit is one. Pending bits whose data bit is zero keep their value.
- R4: When a source pulse and an acknowledge hit the same pending bit in the same cycle, the bit ends up set.
- R5: `irq` is a level: it is high exactly while the global enable is one and (mask AND pending) is nonzero. It follows each register change one cycle after the write or pulse that caused it.
- R6: A write to the low mask half (select 2) or the high mask half (select 3) while the global enable is one raises `irq` on the next cycle if the new mask covers any pending bit.
- R7: A write to select 4 stores a one in the global enable if any of the 16 data bits is nonzero, and a zero otherwise. It reads back as 0 or 1 in bit 0. Writing a nonzero value raises `irq` on the next cycle if any unmasked bit is pending.
- R8: `wake` pulses high for exactly one cycle, the cycle after a source pulse whose bit is set in the mask at the time of the pulse. This holds regardless of the global enable.
- R9: Writes to selects 5, 6 and 7 change no register, and reads at those selects return zero.
- R10: `rd_data` is combinational from `rd_sel` and the current register contents, with no added latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pulse | input | 32 | One-cycle interrupt pulses, one per source |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for the write |
| wr_data | input | 16 | Write data |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 16 | Read data for `rd_sel` |
| irq | output | 1 | Interrupt request level to the processor |
| wake | output | 1 | One-cycle pulse that releases a halted processor |

## Verification
A corrupted pending or mask bit shows up on `rd_data` in the very next cycle after the edge that wrote it. It also shows on `irq` in that same cycle whenever the global enable is on. A wrong wake qualification shows as a missing or extra `wake` pulse exactly one cycle after the source pulse. The bench reads back all register selects after every edge, so no error can stay hidden longer than one clock.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  parameter int unsigned IC_HALF_W = 16;
  parameter int unsigned IC_SEL_W  = 3;
  localparam int unsigned IC_SRC_W = 2 * IC_HALF_W;

  typedef enum logic [IC_SEL_W-1:0] {
    SEL_PEND_LO = 3'd0,
    SEL_PEND_HI = 3'd1,
    SEL_MASK_LO = 3'd2,
    SEL_MASK_HI = 3'd3,
    SEL_GLOBAL  = 3'd4
  } reg_sel_e;

  // Acknowledge mask produced by a write to one pending half.
  function automatic logic [IC_SRC_W-1:0] f_ack_mask(
    input logic                  we,
    input logic [IC_SEL_W-1:0]   sel,
    input logic [IC_HALF_W-1:0]  data
  );
    logic [IC_SRC_W-1:0] m;
    m = '0;
    if (we && sel == SEL_PEND_LO) m[IC_HALF_W-1:0]        = data;
    if (we && sel == SEL_PEND_HI) m[IC_SRC_W-1:IC_HALF_W] = data;
    return m;
  endfunction

  // Next pending value: acknowledge first, then new pulses on top.
  function automatic logic [IC_HALF_W-1:0] f_pend_next(
    input logic [IC_HALF_W-1:0] cur,
    input logic [IC_HALF_W-1:0] ack,
    input logic [IC_HALF_W-1:0] set
  );
    return (cur & ~ack) | set;
  endfunction

  function automatic logic f_any_live(
    input logic [IC_SRC_W-1:0] mask,
    input logic [IC_SRC_W-1:0] pend
  );
    return |(mask & pend);
  endfunction

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
  import irq_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IC_SRC_W-1:0] src_pulse,
  input  logic [IC_SRC_W-1:0] ack_mask,
  output logic [IC_SRC_W-1:0] pend
);

  localparam int unsigned NUM_HALVES = IC_SRC_W / IC_HALF_W;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic [IC_HALF_W-1:0] pend_q;
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else pend_q <= f_pend_next(pend_q,
                                 ack_mask[h*IC_HALF_W +: IC_HALF_W],
                                 src_pulse[h*IC_HALF_W +: IC_HALF_W]);
    end
    assign pend[h*IC_HALF_W +: IC_HALF_W] = pend_q;
  end

  // Named events for the checks below.
  logic [IC_SRC_W-1:0] race_evt;
  logic [IC_SRC_W-1:0] pure_ack_evt;
  assign race_evt     = src_pulse & ack_mask;
  assign pure_ack_evt = ack_mask & ~src_pulse;

  assert_set_beats_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|race_evt) |=> ((pend & $past(race_evt)) == $past(race_evt)));

  assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|pure_ack_evt) |=> ((pend & $past(pure_ack_evt)) == '0));

  assert_pulse_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|src_pulse) |=> ((pend & $past(src_pulse)) == $past(src_pulse)));

endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IC_SEL_W-1:0]  wr_sel,
  input  logic [IC_HALF_W-1:0] wr_data,
  output logic [IC_SRC_W-1:0]  mask,
  output logic                 glb_en
);

  localparam int unsigned NUM_HALVES = IC_SRC_W / IC_HALF_W;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic hit;
    logic [IC_HALF_W-1:0] mask_q;
    assign hit = wr_en && (wr_sel == IC_SEL_W'(SEL_MASK_LO + h));
    always_ff @(posedge clk) begin
      if (!rst_n) mask_q <= '0;
      else if (hit) mask_q <= wr_data;
    end
    assign mask[h*IC_HALF_W +: IC_HALF_W] = mask_q;
  end

  logic glb_wr_evt;
  logic glb_q;
  assign glb_wr_evt = wr_en && (wr_sel == SEL_GLOBAL);

  always_ff @(posedge clk) begin
    if (!rst_n) glb_q <= 1'b0;
    else if (glb_wr_evt) glb_q <= |wr_data;
  end
  assign glb_en = glb_q;

  assert_glb_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    glb_wr_evt |=> (glb_en == $past(|wr_data)));

endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
  import irq_ctrl_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IC_SRC_W-1:0] src_pulse,
  input  logic [IC_SRC_W-1:0] mask,
  input  logic [IC_SRC_W-1:0] pend,
  input  logic                glb_en,
  output logic                irq,
  output logic                wake
);

  logic wake_evt;
  logic wake_q;

  assign wake_evt = |(src_pulse & mask);
  assign irq      = glb_en & f_any_live(mask, pend);

  always_ff @(posedge clk) begin
    if (!rst_n) wake_q <= 1'b0;
    else wake_q <= wake_evt;
  end
  assign wake = wake_q;

  assert_wake_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> wake);

  assert_wake_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_evt |=> !wake);

  assert_irq_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> glb_en);

endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IC_SRC_W-1:0]  src_pulse,
  input  logic                 wr_en,
  input  logic [IC_SEL_W-1:0]  wr_sel,
  input  logic [IC_HALF_W-1:0] wr_data,
  input  logic [IC_SEL_W-1:0]  rd_sel,
  output logic [IC_HALF_W-1:0] rd_data,
  output logic                 irq,
  output logic                 wake
);

  logic [IC_SRC_W-1:0] ack_mask;
  logic [IC_SRC_W-1:0] pend;
  logic [IC_SRC_W-1:0] mask;
  logic                glb_en;

  assign ack_mask = f_ack_mask(wr_en, wr_sel, wr_data);

  irq_pend_bank u_pend (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .ack_mask  (ack_mask),
    .pend      (pend)
  );

  irq_mask_regs u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .mask    (mask),
    .glb_en  (glb_en)
  );

  irq_req_gen u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .mask      (mask),
    .pend      (pend),
    .glb_en    (glb_en),
    .irq       (irq),
    .wake      (wake)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_PEND_LO: rd_data = pend[IC_HALF_W-1:0];
      SEL_PEND_HI: rd_data = pend[IC_SRC_W-1:IC_HALF_W];
      SEL_MASK_LO: rd_data = mask[IC_HALF_W-1:0];
      SEL_MASK_HI: rd_data = mask[IC_SRC_W-1:IC_HALF_W];
      SEL_GLOBAL:  rd_data = {{(IC_HALF_W-1){1'b0}}, glb_en};
      default:     rd_data = '0;
    endcase
  end

  // Events that re-evaluate the request on a mask or global write.
  logic mask_lo_arm_evt;
  logic mask_hi_arm_evt;
  logic glb_arm_evt;
  assign mask_lo_arm_evt = wr_en && wr_sel == SEL_MASK_LO && glb_en &&
                           |({mask[IC_SRC_W-1:IC_HALF_W], wr_data} & pend);
  assign mask_hi_arm_evt = wr_en && wr_sel == SEL_MASK_HI && glb_en &&
                           |({wr_data, mask[IC_HALF_W-1:0]} & pend);
  assign glb_arm_evt     = wr_en && wr_sel == SEL_GLOBAL && (|wr_data) &&
                           |(mask & pend);

  assert_mask_write_arms_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_lo_arm_evt || mask_hi_arm_evt) |=> irq);

  assert_glb_write_arms_R7: assert property (@(posedge clk) disable iff (!rst_n)
    glb_arm_evt |=> irq);

  assert_reserved_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel > SEL_GLOBAL) |=> ($stable(mask) && $stable(glb_en)));

endmodule

// File: tb/irq_ctrl_top_tb.sv
`timescale 1ns/100ps
module irq_ctrl_top_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_pulse = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [15:0] wr_data = '0;
  logic [2:0]  rd_sel = '0;
  logic [15:0] rd_data;
  logic        irq;
  logic        wake;

  always #4 clk = ~clk;

  irq_ctrl_top u_dut (
    .clk(clk), .rst_n(rst_n), .src_pulse(src_pulse), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq), .wake(wake)
  );

  // Reference state.
  bit [31:0] m_pend, m_mask;
  bit        m_glb, m_wake;
  int        n_cmp = 0, n_bad = 0;
  string     cur_req = "R1";
  bit        done = 0;

  task automatic chk(input string what, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  function automatic int exp_read(input int sel);
    case (sel)
      0: return int'(m_pend[15:0]);
      1: return int'(m_pend[31:16]);
      2: return int'(m_mask[15:0]);
      3: return int'(m_mask[31:16]);
      4: return int'(m_glb);
      default: return 0;
    endcase
  endfunction

  task automatic compare_all();
    chk("irq", int'(irq), int'(m_glb && ((m_mask & m_pend) != 0)));
    chk("wake", int'(wake), int'(m_wake));
    for (int s = 0; s < 8; s++) begin
      rd_sel = 3'(s);
      #0.2;
      chk($sformatf("rd[%0d]", s), int'(rd_data), exp_read(s));
    end
  endtask

  task automatic step(input bit [31:0] s, input bit w, input bit [2:0] a,
                      input bit [15:0] d);
    bit [31:0] ack;
    @(negedge clk);
    src_pulse = s; wr_en = w; wr_sel = a; wr_data = d;
    @(posedge clk);
    #1;
    ack = 0;
    if (w && a == 0) ack = {16'h0, d};
    if (w && a == 1) ack = {d, 16'h0};
    m_wake = (s & m_mask) != 0;
    m_pend = (m_pend & ~ack) | s;
    if (w && a == 2) m_mask[15:0]  = d;
    if (w && a == 3) m_mask[31:16] = d;
    if (w && a == 4) m_glb = (d != 0);
    compare_all();
  endtask

  task automatic idle();
    step(32'h0, 0, 3'd0, 16'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    m_pend = 0; m_mask = 0; m_glb = 0; m_wake = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    cur_req = "R1"; #0.5; compare_all();

    cur_req = "R2";  step(32'h0010_0008, 0, 3'd0, 16'h0); idle();
    cur_req = "R10"; idle();
    // Wake without global enable.
    cur_req = "R8";  step(32'h0, 1, 3'd2, 16'h0008);
    step(32'h0000_0008, 0, 3'd0, 16'h0); idle();
    step(32'h0000_0100, 0, 3'd0, 16'h0); idle();
    // Nonzero global write with a non-bit-0 value.
    cur_req = "R7";  step(32'h0, 1, 3'd4, 16'h0100); idle();
    cur_req = "R5";  idle(); idle();
    cur_req = "R3";  step(32'h0, 1, 3'd0, 16'h0008); idle();
    step(32'h0, 1, 3'd1, 16'h0000); idle();
    cur_req = "R6";  step(32'h0, 1, 3'd3, 16'h0010); idle();
    cur_req = "R4";  step(32'h0010_0000, 1, 3'd1, 16'h0010); idle();
    cur_req = "R9";  step(32'h0, 1, 3'd5, 16'hFFFF);
    step(32'h0, 1, 3'd6, 16'hFFFF); step(32'h0, 1, 3'd7, 16'hFFFF);
    cur_req = "R5";  step(32'h0, 1, 3'd4, 16'h0000); idle();
    cur_req = "R6";  step(32'h0, 1, 3'd4, 16'h0001);
    step(32'h0, 1, 3'd2, 16'h0100); idle();

    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      bit [31:0] s;
      bit [2:0]  a;
      s = ($urandom_range(0, 3) == 0) ? (32'h1 << $urandom_range(0, 31)) : 32'h0;
      a = 3'($urandom_range(0, 7));
      step(s, $urandom_range(0, 2) == 0, a, 16'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule